// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel for a multi-channel event timer. It watches an externally supplied 64-bit main count. When the count reaches the programmed comparator value, it raises a one-clock expiry pulse. The channel can run as a one-shot or as a periodic source, and it can compare either the full 64 bits or only the low 32 bits.

Software reaches the comparator through 32-bit half-word writes. A self-clearing set-value bit decides whether a write in periodic mode loads only the reload interval or loads the comparator as well. In periodic mode the comparator steps forward by the interval after each expiry. If periods were missed, it keeps stepping until it is ahead again, and it raises only one pulse for the whole catch-up. In 32-bit one-shot mode, a match that lies beyond the next roll-over of the low count word produces an extra pulse at the roll-over. The real match pulse follows later.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones, the interval reads zero, the set-value bit reads 0, and `fire_o` is low.
- R2: When the channel is armed and both enables are high, `fire_o` goes high for one clock on the edge after the clock at which the sampled count satisfies comparator minus count <= 0. The difference is a 64-bit two's-complement value in full-width mode.
- R3: With `mode32_i` high, only the low 32 bits of the count and the comparator take part, and their difference is taken as a 32-bit signed value.
- R4: In one-shot mode (`periodic_i` = 0) the channel fires once and then stays quiet until it is armed again.
- R5: In periodic mode with a non-zero interval, an expiry adds the interval to the comparator. The channel keeps adding, without further pulses, until the comparator is ahead of the count sampled at the expiry. Only one pulse is raised per expiry.
- R6: A half-word write (`wr_lo_i` loads bits 31:0, `wr_hi_i` loads bits 63:32) goes to the comparator in one-shot mode. In periodic mode it goes to the interval, and also to the comparator when the set-value bit is 1. `setval_set_i` sets the bit, and any comparator write clears it.
- R7: A value written into the interval has its top bit cleared. In 32-bit mode this is bit 31 of a low-half write. In 64-bit mode it is bit 63, cleared on a high-half write.
- R8: While `mode32_i` is high, bits 63:32 of the comparator and the interval are held at zero, and high-half writes have no effect.
- R9: If, when a 32-bit one-shot is armed, the count would reach 0xFFFFFFFF in its low word before the match, an extra pulse fires at that value. The match pulse still follows.
- R10: A rising `ch_en_i` while `glb_en_i` is high arms the channel. A rising `glb_en_i` while `ch_en_i` is high arms it only if the comparator is not all ones. Dropping either enable disarms it, and no pulse follows.
- R11: A comparator write while `glb_en_i` is high re-arms the channel against the count on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 64 | Main count value |
| glb_en_i | input | 1 | Global enable of the timer |
| ch_en_i | input | 1 | Channel enable |
| periodic_i | input | 1 | 1 = periodic, 0 = one-shot |
| mode32_i | input | 1 | 1 = 32-bit comparison and storage |
| setval_set_i | input | 1 | Sets the set-value bit |
| wr_lo_i | input | 1 | Write strobe, low comparator half |
| wr_hi_i | input | 1 | Write strobe, high comparator half |
| wr_data_i | input | 32 | Write data |
| fire_o | output | 1 | One-clock expiry pulse |
| cmp_o | output | 64 | Current comparator |
| period_o | output | 64 | Current reload interval |
| setval_o | output | 1 | Set-value bit |

## Verification
The properties assume that the main count advances by zero or one per clock while `glb_en_i` is high. They also assume that `setval_set_i` never coincides with a comparator write. The stimulus keeps within both limits. It moves the count by large jumps only while the global enable is low, and it pulses the set-value bit one clock before each write. The random phase exercises the write routing, clamping and truncation with the global enable low, so that writes never re-arm the channel there. The directed phases step the count one unit per clock across each match and roll-over.

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_i,
  input  logic          glb_en_i,
  input  logic          ch_en_i,
  input  logic          periodic_i,
  input  logic          mode32_i,
  input  logic          setval_set_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [CW/2-1:0] wr_data_i,
  output logic          fire_o,
  output logic [CW-1:0] cmp_o,
  output logic [CW-1:0] period_o,
  output logic          setval_o
);
  localparam int HW = CW / 2;

  logic [CW-1:0] cmp_q, per_q, snap_q;
  logic armed_q, wrap_q, catch_q, en_q, glb_q, rearm_q, setval_q, fire_q;

  wire [CW-1:0] d_full = cmp_q - count_i;
  wire [HW-1:0] d_half = cmp_q[HW-1:0] - count_i[HW-1:0];
  wire expired = mode32_i ? (d_half[HW-1] | ~|d_half) : (d_full[CW-1] | ~|d_full);

  wire [CW-1:0] s_full = cmp_q - snap_q;
  wire [HW-1:0] s_half = cmp_q[HW-1:0] - snap_q[HW-1:0];
  wire behind_snap = mode32_i ? (s_half[HW-1] | ~|s_half) : (s_full[CW-1] | ~|s_full);

  wire [CW-1:0] cmp_adv = mode32_i ? {{HW{1'b0}}, cmp_q[HW-1:0] + per_q[HW-1:0]}
                                   : cmp_q + per_q;

  wire [HW-1:0] d_eff = (d_half[HW-1] | ~|d_half) ? HW'(1) : d_half;
  wire [HW-1:0] to_wrap = ~count_i[HW-1:0];
  wire wrap_need = mode32_i & ~periodic_i & (to_wrap < d_eff);
  wire at_wrap = &count_i[HW-1:0];

  wire live = ch_en_i & glb_en_i;
  wire arm  = live & (~en_q | (~glb_q & ~&cmp_q) | rearm_q);
  wire to_cmp = ~periodic_i | setval_q;
  wire [HW-1:0] lo_per = mode32_i ? {1'b0, wr_data_i[HW-2:0]} : wr_data_i;
  wire any_wr = wr_lo_i | wr_hi_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q    <= '1;
      per_q    <= '0;
      snap_q   <= '0;
      armed_q  <= 1'b0;
      wrap_q   <= 1'b0;
      catch_q  <= 1'b0;
      en_q     <= 1'b0;
      glb_q    <= 1'b0;
      rearm_q  <= 1'b0;
      setval_q <= 1'b0;
      fire_q   <= 1'b0;
    end else begin
      fire_q  <= 1'b0;
      en_q    <= ch_en_i;
      glb_q   <= glb_en_i;
      rearm_q <= any_wr & glb_en_i;

      if (!live) begin
        armed_q <= 1'b0;
        wrap_q  <= 1'b0;
        catch_q <= 1'b0;
      end else if (arm) begin
        armed_q <= 1'b1;
        wrap_q  <= wrap_need;
        catch_q <= 1'b0;
      end else if (armed_q) begin
        if (catch_q) begin
          if (behind_snap) cmp_q <= cmp_adv;
          else             catch_q <= 1'b0;
        end else if (wrap_q) begin
          if (at_wrap) begin
            fire_q <= 1'b1;
            wrap_q <= 1'b0;
          end
        end else if (expired) begin
          fire_q <= 1'b1;
          if (periodic_i && per_q != '0) begin
            cmp_q   <= cmp_adv;
            catch_q <= 1'b1;
            snap_q  <= count_i;
          end else begin
            armed_q <= 1'b0;
          end
        end
      end

      if (wr_lo_i) begin
        if (to_cmp)     cmp_q[HW-1:0] <= wr_data_i;
        if (periodic_i) per_q[HW-1:0] <= lo_per;
      end
      if (wr_hi_i && !mode32_i) begin
        if (to_cmp)     cmp_q[CW-1:HW] <= wr_data_i;
        if (periodic_i) per_q[CW-1:HW] <= {1'b0, wr_data_i[HW-2:0]};
      end

      if (any_wr)            setval_q <= 1'b0;
      else if (setval_set_i) setval_q <= 1'b1;

      if (mode32_i) begin
        cmp_q[CW-1:HW] <= '0;
        per_q[CW-1:HW] <= '0;
      end
    end
  end

  assign fire_o   = fire_q;
  assign cmp_o    = cmp_q;
  assign period_o = per_q;
  assign setval_o = setval_q;
endmodule

// File: rtl/evt_cmp_channel_chk.sv
module evt_cmp_channel_chk #(
  parameter int CW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ch_en_i,
  input logic          glb_en_i,
  input logic          periodic_i,
  input logic          mode32_i,
  input logic          wr_lo_i,
  input logic          wr_hi_i,
  input logic          fire_o,
  input logic [CW-1:0] cmp_o,
  input logic [CW-1:0] period_o,
  input logic          setval_o
);
  localparam int HW = CW / 2;

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (cmp_o == '1 && period_o == '0 && !setval_o && !fire_o)); // R1

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && $past(periodic_i)) |=> !fire_o); // R5

  AST_OFF_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en_i || !glb_en_i) |=> !fire_o); // R10

  AST_SETVAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_i || wr_hi_i) |=> !setval_o); // R6

  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_i && periodic_i && mode32_i) |=> !period_o[HW-1]); // R7

  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_i && periodic_i && !mode32_i) |=> !period_o[CW-1]); // R7

  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode32_i)) |-> (cmp_o[CW-1:HW] == '0 && period_o[CW-1:HW] == '0)); // R8
endmodule

bind evt_cmp_channel evt_cmp_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_en_i(ch_en_i), .glb_en_i(glb_en_i),
  .periodic_i(periodic_i), .mode32_i(mode32_i), .wr_lo_i(wr_lo_i),
  .wr_hi_i(wr_hi_i), .fire_o(fire_o), .cmp_o(cmp_o), .period_o(period_o),
  .setval_o(setval_o)
);

// File: tb/tb_evt_cmp_channel.sv
`timescale 1ns/1ps
module tb_evt_cmp_channel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic glb_en = 0, ch_en = 0, periodic = 0, mode32 = 0, setval_set = 0;
  logic wr_lo = 0, wr_hi = 0;
  logic [31:0] wdat = '0;
  logic fire_o, setval_o;
  logic [63:0] cmp_o, period_o;

  int checks = 0, fails = 0, nf = 0;
  logic [63:0] fa [4];
  bit run = 0, done = 0;

  always #4 clk = ~clk;

  evt_cmp_channel dut (
    .clk(clk), .rst_n(rst_n), .count_i(cnt), .glb_en_i(glb_en), .ch_en_i(ch_en),
    .periodic_i(periodic), .mode32_i(mode32), .setval_set_i(setval_set),
    .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wr_data_i(wdat),
    .fire_o(fire_o), .cmp_o(cmp_o), .period_o(period_o), .setval_o(setval_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (fire_o) begin
      if (nf < 4) fa[nf] = cnt;
      nf++;
    end
    if (run) cnt = cnt + 1;
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(bit hi, logic [31:0] d);
    if (hi) wr_hi = 1; else wr_lo = 1;
    wdat = d;
    cyc();
    wr_hi = 0;
    wr_lo = 0;
  endtask

  function automatic void model_wr(input bit p, input bit m, input bit hi, input bit sv,
                                   input logic [31:0] d,
                                   inout logic [63:0] c, inout logic [63:0] pr);
    bit tc = !p || sv;
    if (!hi) begin
      if (tc) c[31:0] = d;
      if (p)  pr[31:0] = m ? {1'b0, d[30:0]} : d;
    end else if (!m) begin
      if (tc) c[63:32] = d;
      if (p)  pr[63:32] = {1'b0, d[30:0]};
    end
    if (m) begin
      c[63:32] = '0;
      pr[63:32] = '0;
    end
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] tgt, mcmp, mper;
    bit msv;
    void'($urandom(32'd20240611));
    run_n(3);
    rst_n = 1;
    cyc();
    chk("R1 cmp", cmp_o, '1);
    chk("R1 period", period_o, '0);
    chk("R1 setval", {63'd0, setval_o}, 64'd0);
    chk("R1 fire", {63'd0, fire_o}, 64'd0);

    // 64-bit one-shot
    cnt = 64'h1_0000_0000;
    wr(0, 32'h10);
    wr(1, 32'h1);
    chk("R6 one-shot write", cmp_o, 64'h1_0000_0010);
    ch_en = 1;
    cyc();
    glb_en = 1; run = 1; nf = 0;
    run_n(40);
    chk("R2 fire count", nf, 1);
    chk("R2 match value", fa[0], 64'h1_0000_0010);
    run_n(40);
    chk("R4 single shot", nf, 1);

    // 32-bit compare and truncation
    glb_en = 0; cyc(); run = 0;
    mode32 = 1; cyc();
    chk("R8 truncate", cmp_o, 64'h10);
    wr(1, 32'h55);
    chk("R8 high write ignored", cmp_o, 64'h10);
    wr(0, 32'h20);
    cnt = 64'h7_0000_0010;
    glb_en = 1; run = 1; nf = 0;
    run_n(40);
    chk("R3 fire count", nf, 1);
    chk("R3 low-word match", fa[0], 64'h7_0000_0020);

    // 32-bit roll-over event
    glb_en = 0; run = 0; cyc();
    wr(0, 32'h10);
    cnt = 64'hFFFF_FFF0;
    nf = 0; glb_en = 1; run = 1;
    run_n(60);
    chk("R9 two pulses", nf, 2);
    chk("R9 wrap pulse", fa[0], 64'hFFFF_FFFF);
    chk("R9 match pulse", fa[1], 64'h1_0000_0010);

    // periodic catch-up
    glb_en = 0; run = 0; cyc();
    mode32 = 0; periodic = 1; setval_set = 1; cyc(); setval_set = 0;
    chk("R6 setval set", {63'd0, setval_o}, 64'd1);
    wr(0, 32'd100);
    chk("R6 setval self-clear", {63'd0, setval_o}, 64'd0);
    wr(1, 32'd0);
    chk("R6 cmp via setval", cmp_o, 64'd100);
    chk("R6 period", period_o, 64'd100);
    cnt = 64'd1000; nf = 0; glb_en = 1; run = 1;
    run_n(250);
    chk("R5 pulse count", nf, 3);
    chk("R5 first after catch-up", fa[0], 64'd1001);
    chk("R5 second", fa[1], 64'd1100);
    chk("R5 third", fa[2], 64'd1200);
    chk("R5 cmp advanced", cmp_o, 64'd1300);

    // clamping
    glb_en = 0; run = 0; cyc();
    wr(1, 32'hFFFF_FFFF);
    chk("R7 clamp bit 63", period_o, 64'h7FFF_FFFF_0000_0064);
    chk("R6 period-only write", cmp_o, 64'd1300);
    mode32 = 1; cyc();
    wr(0, 32'hFFFF_FFFF);
    chk("R7 clamp bit 31", period_o, 64'h7FFF_FFFF);

    // arming rules
    mode32 = 0; periodic = 0;
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    chk("R6 all ones", cmp_o, '1);
    cnt = 64'd5000; nf = 0; glb_en = 1; run = 1;
    run_n(20);
    chk("R10 global rise skips all ones", nf, 0);
    ch_en = 0; cyc(); ch_en = 1;
    run_n(10);
    chk("R10 channel rise arms", nf, 1);

    // write re-arms
    nf = 0;
    wr(1, 32'h0);
    tgt = cnt + 30;
    wr(0, tgt[31:0]);
    run_n(40);
    chk("R11 rearm fires", nf, 1);
    chk("R11 match value", fa[0], tgt);

    // disarm
    nf = 0;
    tgt = cnt + 20;
    wr(0, tgt[31:0]);
    run_n(5);
    ch_en = 0;
    run_n(40);
    chk("R10 disarm", nf, 0);

    // random write routing
    glb_en = 0; run = 0; cyc();
    mcmp = cmp_o; mper = period_o; msv = setval_o;
    for (int k = 0; k < 200; k++) begin
      bit p, m, s, hi;
      logic [31:0] d;
      p = 1'($urandom); m = 1'($urandom); s = 1'($urandom); hi = 1'($urandom);
      d = $urandom;
      periodic = p; mode32 = m; setval_set = s;
      cyc();
      setval_set = 0;
      if (s) msv = 1;
      if (m) begin mcmp[63:32] = '0; mper[63:32] = '0; end
      wr(hi, d);
      model_wr(p, m, hi, msv, d, mcmp, mper);
      msv = 0;
      chk("R6 random cmp", cmp_o, mcmp);
      chk("R7 random period", period_o, mper);
      chk("R8 random setval", {63'd0, setval_o}, 64'd0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule